// File: doc/BRIEF.md
# Memory Reference Address Generator

This block computes the 16-bit effective address of a memory-reference instruction for a small 16-bit processor. It takes the instruction word, an optional second word that carries a full-width displacement, the program counter, and two index accumulators. A 2-bit mode field in the instruction chooses the addressing mode. Mode 0 uses the displacement as an unsigned offset into a 256-word base page. Mode 1 adds a signed offset to the program counter. Modes 2 and 3 add a signed offset to one of the two index accumulators.

For an indirect reference, the block first puts the computed pointer address on `ind_addr` and raises `ind_req`. It waits for the pointer word to come back on `ptr_data` with `ptr_valid`. It then issues that word as the final address. Each finished address is registered and marked by a one-cycle pulse on `ea_valid`. The control sequencer drives `start`, `indirect` and `dword` from its own decode.

Top module: `mref_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ea_valid` and `ind_req` are 0 and `ea` is 0.
- R2: The mode field is insn[9:8] and the short displacement is insn[7:0]. With mode 0 and `dword` low, the address is insn[7:0] zero-extended (0 to 255).
- R3: With mode 1, the address is `pc_next` plus insn[7:0] taken as a signed value (-128 to +127). `pc_next` is the counter after it has stepped past the whole instruction.
- R4: With mode 2 the address is `idx2` plus the signed displacement. With mode 3 it is `idx3` plus the signed displacement.
- R5: When `dword` is high, `ext_word` takes the place of the short displacement as a full 16-bit offset, in every mode. With mode 0 this makes the address equal to `ext_word`.
- R6: All address sums wrap modulo 65536.
- R7: A direct request (`start` high, `indirect` low, no pointer pending) gives `ea` with `ea_valid` high for exactly the next cycle. Requests on consecutive cycles give consecutive pulses.
- R8: An indirect request raises `ind_req` in the next cycle, with the computed pointer address on `ind_addr`. Both stay unchanged until `ptr_valid` is sampled high.
- R9: In the cycle after `ptr_valid` is sampled with `ind_req` high, `ind_req` is low, `ea_valid` is high and `ea` equals the sampled `ptr_data`.
- R10: `start` is ignored while `ind_req` is high. `ptr_valid` is ignored while `ind_req` is low. Neither one produces an `ea_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present for address generation |
| insn | input | 16 | Instruction word (mode [9:8], displacement [7:0]) |
| dword | input | 1 | Double-word format: use ext_word as offset |
| ext_word | input | 16 | Second instruction word, 16-bit displacement |
| indirect | input | 1 | Reference is indirect through a pointer word |
| pc_next | input | 16 | Program counter past the instruction |
| idx2 | input | 16 | Index accumulator selected by mode 2 |
| idx3 | input | 16 | Index accumulator selected by mode 3 |
| ptr_valid | input | 1 | Pointer word returned |
| ptr_data | input | 16 | Returned pointer word |
| ind_req | output | 1 | Pointer fetch requested |
| ind_addr | output | 16 | Address of the pointer word |
| ea_valid | output | 1 | One-cycle pulse: ea is final |
| ea | output | 16 | Registered effective address |

## Verification
The displacement patterns include 0x00, 0x7F, 0x80 and 0xFF, so the tests tell zero-extension (mode 0) apart from sign-extension (modes 1 to 3). The base values sit next to 0x0000 and 0xFFFF so that wrap-around shows. The index registers and the program counter carry different values from each other, so a wrong base selection changes the result. Double-word cases use offsets with the top bit set, which exposes a short displacement leaking through.

Indirect runs vary the wait before `ptr_valid` and inject `start` during the wait and `ptr_valid` while idle, which separates a hold-and-ignore sequencer from one that restarts. A long mixed run with random modes is also compared cycle by cycle against a behavioural model.

// File: rtl/mref_pkg.sv
package mref_pkg;
   typedef enum logic [1:0] {
      MODE_PAGE  = 2'd0,
      MODE_PCREL = 2'd1,
      MODE_IDX2  = 2'd2,
      MODE_IDX3  = 2'd3
   } xr_mode_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_PTR  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/mref_offset.sv
module mref_offset #(
   parameter int ADDR_W   = 16,
   parameter int DISP_W   = 8,
   parameter bit DWORD_EN = 1'b1
) (
   input  logic [DISP_W-1:0] disp,
   input  logic              zext,
   input  logic              dword,
   input  logic [ADDR_W-1:0] ext_word,
   output logic [ADDR_W-1:0] offset
);
   localparam int PAD_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] short_off;

   always_comb begin
      if (zext) short_off = {{PAD_W{1'b0}}, disp};
      else      short_off = {{PAD_W{disp[DISP_W-1]}}, disp};
   end

   generate
      if (DWORD_EN) begin : g_dword
         assign offset = dword ? ext_word : short_off;
      end else begin : g_single
         logic unused_dw;
         assign unused_dw = dword ^ (^ext_word);
         assign offset = short_off;
      end
   endgenerate
endmodule

// File: rtl/mref_base_sel.sv
module mref_base_sel
   import mref_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  xr_mode_e          mode,
   input  logic [ADDR_W-1:0] pc_next,
   input  logic [ADDR_W-1:0] idx2,
   input  logic [ADDR_W-1:0] idx3,
   output logic [ADDR_W-1:0] base
);
   always_comb begin
      unique case (mode)
         MODE_PAGE:  base = '0;
         MODE_PCREL: base = pc_next;
         MODE_IDX2:  base = idx2;
         default:    base = idx3;
      endcase
   end
endmodule

// File: rtl/mref_seq.sv
module mref_seq
   import mref_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              indirect,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ptr_valid,
   input  logic [ADDR_W-1:0] ptr_data,
   output logic              ind_req,
   output logic [ADDR_W-1:0] ind_addr,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea
);
   seq_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         ea       <= '0;
         ea_valid <= 1'b0;
         ind_addr <= '0;
      end else begin
         ea_valid <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  if (indirect) begin
                     state    <= SEQ_PTR;
                     ind_addr <= addr;
                  end else begin
                     ea       <= addr;
                     ea_valid <= 1'b1;
                  end
               end
            end
            default: begin
               if (ptr_valid) begin
                  ea       <= ptr_data;
                  ea_valid <= 1'b1;
                  state    <= SEQ_IDLE;
               end
            end
         endcase
      end
   end

   assign ind_req = (state == SEQ_PTR);

   assert_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ind_req && start && !indirect) |=> (ea_valid && ea == $past(addr)));

   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_req && !ptr_valid) |=> (ind_req && $stable(ind_addr)));

   assert_ptr_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_req && ptr_valid) |=> (ea_valid && !ind_req && ea == $past(ptr_data)));

   assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_req && !ptr_valid) |=> !ea_valid);
endmodule

// File: rtl/mref_addr_gen.sv
module mref_addr_gen
   import mref_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DISP_W   = 8,
   parameter int XR_LSB   = 8,
   parameter bit DWORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] insn,
   input  logic              dword,
   input  logic [ADDR_W-1:0] ext_word,
   input  logic              indirect,
   input  logic [ADDR_W-1:0] pc_next,
   input  logic [ADDR_W-1:0] idx2,
   input  logic [ADDR_W-1:0] idx3,
   input  logic              ptr_valid,
   input  logic [ADDR_W-1:0] ptr_data,
   output logic              ind_req,
   output logic [ADDR_W-1:0] ind_addr,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea
);
   localparam int PAD_W = ADDR_W - DISP_W;

   generate
      if (DISP_W >= ADDR_W) begin : g_bad_disp
         $error("DISP_W must be narrower than ADDR_W");
      end
      if (XR_LSB + 2 > ADDR_W || XR_LSB < DISP_W) begin : g_bad_xr
         $error("mode field must sit above the displacement inside the word");
      end
   endgenerate

   xr_mode_e          mode;
   logic [DISP_W-1:0] disp;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] addr;

   assign mode = xr_mode_e'(insn[XR_LSB +: 2]);
   assign disp = insn[DISP_W-1:0];

   mref_base_sel #(.ADDR_W(ADDR_W)) u_base (
      .mode    (mode),
      .pc_next (pc_next),
      .idx2    (idx2),
      .idx3    (idx3),
      .base    (base)
   );

   mref_offset #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .DWORD_EN(DWORD_EN)) u_off (
      .disp     (disp),
      .zext     (mode == MODE_PAGE),
      .dword    (dword),
      .ext_word (ext_word),
      .offset   (offset)
   );

   assign addr = base + offset;

   mref_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .indirect  (indirect),
      .addr      (addr),
      .ptr_valid (ptr_valid),
      .ptr_data  (ptr_data),
      .ind_req   (ind_req),
      .ind_addr  (ind_addr),
      .ea_valid  (ea_valid),
      .ea        (ea)
   );

   assert_page_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ind_req && !indirect && !dword && mode == MODE_PAGE)
      |=> (ea == {{PAD_W{1'b0}}, $past(disp)}));

   assert_never_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req |-> !ea_valid);
endmodule

// File: tb/mref_addr_gen_bench.sv
module mref_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] insn = '0;
   logic        dword = 1'b0;
   logic [15:0] ext_word = '0;
   logic        indirect = 1'b0;
   logic [15:0] pc_next = '0;
   logic [15:0] idx2 = '0;
   logic [15:0] idx3 = '0;
   logic        ptr_valid = 1'b0;
   logic [15:0] ptr_data = '0;
   logic        ind_req;
   logic [15:0] ind_addr;
   logic        ea_valid;
   logic [15:0] ea;

   int checks = 0;
   int fails = 0;
   string tag = "R1";
   bit running = 1'b1;

   always #2.5 clk = ~clk;

   mref_addr_gen u_mref_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .dword(dword),
      .ext_word(ext_word), .indirect(indirect), .pc_next(pc_next),
      .idx2(idx2), .idx3(idx3), .ptr_valid(ptr_valid), .ptr_data(ptr_data),
      .ind_req(ind_req), .ind_addr(ind_addr), .ea_valid(ea_valid), .ea(ea)
   );

   // behavioural reference
   bit m_wait = 0, m_valid = 0;
   int m_ea = 0, m_ptr = 0;

   function automatic int ref_addr();
      int off, b, d;
      d = int'(insn[7:0]);
      case (insn[9:8])
         2'd0: b = 0;
         2'd1: b = int'(pc_next);
         2'd2: b = int'(idx2);
         default: b = int'(idx3);
      endcase
      if (dword) off = int'(ext_word);
      else if (insn[9:8] == 2'd0) off = d;
      else off = (d >= 128) ? d - 256 : d;
      return (b + off + 65536) % 65536;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wait <= 0; m_valid <= 0; m_ea <= 0; m_ptr <= 0;
      end else begin
         m_valid <= 0;
         if (!m_wait) begin
            if (start) begin
               if (indirect) begin m_wait <= 1; m_ptr <= ref_addr(); end
               else begin m_ea <= ref_addr(); m_valid <= 1; end
            end
         end else if (ptr_valid) begin
            m_wait <= 0; m_ea <= int'(ptr_data); m_valid <= 1;
         end
      end
   end

   task automatic chk(string t, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running && rst_n) begin
         chk(tag, int'(ea_valid), int'(m_valid), "ea_valid");
         chk(tag, int'(ind_req), int'(m_wait), "ind_req");
         if (m_wait) chk(tag, int'(ind_addr), m_ptr, "ind_addr");
         if (m_valid) chk(tag, int'(ea), m_ea, "ea");
      end
   end

   task automatic issue(string t, logic [1:0] xr, logic [7:0] d, logic dw,
                        logic [15:0] ext, logic ind);
      tag = t;
      insn = {4'h5, 2'b10, xr, d};
      dword = dw; ext_word = ext; indirect = ind; start = 1'b1;
      @(negedge clk);
      start = 1'b0; indirect = 1'b0; dword = 1'b0;
   endtask

   task automatic give_ptr(logic [15:0] p);
      ptr_data = p; ptr_valid = 1'b1;
      @(negedge clk);
      ptr_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", int'(ea_valid), 0, "ea_valid in reset");
      chk("R1", int'(ind_req), 0, "ind_req in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(ea), 0, "ea after reset");
      pc_next = 16'h1234; idx2 = 16'h8000; idx3 = 16'hFFFF;
      issue("R2", 2'd0, 8'h00, 0, 16'h0, 0);
      issue("R2", 2'd0, 8'hFF, 0, 16'h0, 0);
      issue("R2", 2'd0, 8'h80, 0, 16'h0, 0);
      @(negedge clk);
      issue("R3", 2'd1, 8'h7F, 0, 16'h0, 0);
      issue("R3", 2'd1, 8'h80, 0, 16'h0, 0);
      pc_next = 16'h0005;
      issue("R6", 2'd1, 8'hF0, 0, 16'h0, 0);
      issue("R4", 2'd2, 8'h10, 0, 16'h0, 0);
      issue("R4", 2'd2, 8'hFE, 0, 16'h0, 0);
      issue("R6", 2'd3, 8'h01, 0, 16'h0, 0);
      issue("R4", 2'd3, 8'h80, 0, 16'h0, 0);
      @(negedge clk);
      pc_next = 16'h0100;
      issue("R5", 2'd1, 8'h00, 1, 16'h8000, 0);
      issue("R5", 2'd0, 8'h12, 1, 16'hABCD, 0);
      issue("R5", 2'd3, 8'h7F, 1, 16'h0002, 0);
      issue("R7", 2'd2, 8'h01, 0, 16'h0, 0);
      @(negedge clk);
      issue("R8", 2'd1, 8'h40, 0, 16'h0, 1);
      repeat (3) @(negedge clk);
      tag = "R9";
      give_ptr(16'hC0DE);
      @(negedge clk);
      issue("R8", 2'd2, 8'hF0, 1, 16'h0300, 1);
      issue("R10", 2'd0, 8'h33, 0, 16'h0, 0);
      issue("R10", 2'd0, 8'h44, 0, 16'h0, 1);
      tag = "R9";
      give_ptr(16'hFFFF);
      tag = "R10";
      give_ptr(16'h1111);
      @(negedge clk);
      for (int i = 0; i < 300; i++) begin
         pc_next = 16'($urandom); idx2 = 16'($urandom); idx3 = 16'($urandom);
         issue("R7", 2'($urandom), 8'($urandom), 1'($urandom),
               16'($urandom), 1'(($urandom % 4) == 0));
         if (ind_req) begin
            repeat ($urandom % 3) @(negedge clk);
            tag = "R9";
            give_ptr(16'($urandom));
         end
      end
      repeat (3) @(negedge clk);
      running = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (running) begin
         running = 1'b0;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule